// File: doc/BRIEF.md
# Shadowed Nonvolatile RAM Controller

This block is a 256-word by 4-bit static RAM with a nonvolatile shadow array of the same shape behind it. The host reaches the RAM through a plain SRAM-style port: an address, a write data bus, a read data bus, and active-low chip select and write enable. Two further active-low strobes move the whole array at once. A store strobe copies every RAM word into the shadow. A recall strobe copies every shadow word back into the RAM.

A sequencer walks all addresses, one word per clock, for each bulk copy. It then holds a busy output high until a cycle budget has run out. The budget stands in for the programming time of the nonvolatile cells. Stores take a long budget and recalls a much shorter one. While busy is high, host reads and writes are refused. A low-supply input blocks store requests. Leaving reset runs a recall by itself, so the RAM always starts with the shadow contents. A counter records the number of stores that have completed.

The shadow array is never cleared by reset, so data written to it survives a reset. All inputs are taken to be synchronous to the clock.

Top module: `nvsram_ctrl`

## Requirements
- R1: With busy low, chip select low and write enable low store data_i at addr_i on the clock edge. Chip select low and write enable high load the addressed word onto data_o at the clock edge. data_o is 0 after reset and otherwise holds its value.
- R2: A store copies all 256 RAM words into the shadow array, bit for bit.
- R3: A recall copies all 256 shadow words into the RAM, bit for bit, and replaces any host writes made since then.
- R4: An accepted store holds busy_o high for exactly STORE_CYC clock cycles, starting at the edge that samples the strobe's falling edge.
- R5: An accepted recall holds busy_o high for exactly RECALL_CYC cycles, counted the same way.
- R6: While busy_o is high, host writes leave the RAM unchanged and host reads leave data_o unchanged.
- R7: A store falling edge sampled while vlow_i is 1 is ignored. busy_o stays low, store_cnt_o is unchanged and the shadow array is unchanged.
- R8: store_cnt_o resets to 0 and rises by exactly one at the end of each completed store. It does not change otherwise.
- R9: If store and recall fall at the same clock edge, only the recall runs. A falling edge on either strobe while busy_o is high is dropped.
- R10: busy_o is high during reset. On release, a recall runs for RECALL_CYC cycles and loads the shadow contents into the RAM.
- R11: The strobes act on their falling edge only. Holding a strobe low does not start another transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host word address |
| data_i | input | DATA_W | Host write data |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write enable, active low |
| store_ni | input | 1 | Store strobe (RAM to shadow), falling edge |
| recall_ni | input | 1 | Recall strobe (shadow to RAM), falling edge |
| vlow_i | input | 1 | Supply-low flag; blocks stores |
| data_o | output | DATA_W | Registered host read data |
| busy_o | output | 1 | Bulk transfer in progress |
| store_cnt_o | output | CNT_W | Completed store count |

## Verification
The assertions check on every cycle that data_o stays frozen while busy is high, that the store counter moves only in single steps at the moment busy falls, and that no store starts after a sampled low-supply flag. They also check that every start of busy follows a strobe edge, and that a recall edge arriving together with a store edge starts a recall. Only the bench's scenarios can show the bulk contents: every word is carried across a store and a recall, and the shadow survives reset and is auto-recalled. The bench also checks the exact busy lengths, and that writes made while busy is high, held-low strobes and dropped requests leave no trace.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_STORE  = 2'd1,
    OP_RECALL = 2'd2
  } op_e;
endpackage

// File: rtl/nvsram_req.sv
module nvsram_req
  import nvsram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic store_ni,
  input  logic recall_ni,
  input  logic vlow_i,
  input  logic idle_i,
  output logic start_o,
  output op_e  start_op_o
);
  logic st_q, rc_q, st_fall, rc_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= 1'b1;
      rc_q <= 1'b1;
    end else begin
      st_q <= store_ni;
      rc_q <= recall_ni;
    end
  end

  assign st_fall = st_q & ~store_ni;
  assign rc_fall = rc_q & ~recall_ni;

  // recall wins; busy drops both; low supply drops store
  always_comb begin
    start_o    = 1'b0;
    start_op_o = OP_IDLE;
    if (idle_i) begin
      if (rc_fall) begin
        start_o    = 1'b1;
        start_op_o = OP_RECALL;
      end else if (st_fall && !vlow_i) begin
        start_o    = 1'b1;
        start_op_o = OP_STORE;
      end
    end
  end
endmodule

// File: rtl/nvsram_seq.sv
module nvsram_seq
  import nvsram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned STORE_CYC  = 2000,
  parameter int unsigned RECALL_CYC = 300,  // must be >= 2**ADDR_W
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               start_op_i,
  output op_e               op_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic              copy_st_o,
  output logic              copy_rc_o,
  output logic [CNT_W-1:0]  store_cnt_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned MAXC  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int unsigned TOPC  = (MAXC > DEPTH) ? MAXC : DEPTH;
  localparam int unsigned TMR_W = $clog2(TOPC + 1);

  op_e              op_q;
  logic [TMR_W-1:0] tmr_q, last;
  logic [CNT_W-1:0] cnt_q;
  logic             in_copy;

  assign last    = (op_q == OP_STORE) ? TMR_W'(STORE_CYC - 1) : TMR_W'(RECALL_CYC - 1);
  assign in_copy = tmr_q < TMR_W'(DEPTH);

  // reset value starts the power-up recall
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_RECALL;
      tmr_q <= '0;
      cnt_q <= '0;
    end else if (op_q == OP_IDLE) begin
      if (start_i) begin
        op_q  <= start_op_i;
        tmr_q <= '0;
      end
    end else if (tmr_q == last) begin
      if (op_q == OP_STORE) cnt_q <= cnt_q + 1'b1;
      op_q <= OP_IDLE;
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  assign op_o        = op_q;
  assign busy_o      = op_q != OP_IDLE;
  assign idx_o       = tmr_q[ADDR_W-1:0];
  assign copy_st_o   = (op_q == OP_STORE) && in_copy;
  assign copy_rc_o   = (op_q == OP_RECALL) && in_copy;
  assign store_cnt_o = cnt_q;
endmodule

// File: rtl/nvsram_arrays.sv
module nvsram_arrays #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic              copy_st_i,
  input  logic              copy_rc_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram_q [DEPTH];
  logic [DATA_W-1:0] nv_q  [DEPTH];
  logic              host_rd, host_wr;

  assign host_rd = !cs_ni &&  we_ni && !busy_i;
  assign host_wr = !cs_ni && !we_ni && !busy_i;

  // arrays carry no reset: the shadow must survive it
  always_ff @(posedge clk_i) begin
    if (copy_rc_i)    ram_q[idx_i]  <= nv_q[idx_i];
    else if (host_wr) ram_q[addr_i] <= data_i;
    if (copy_st_i)    nv_q[idx_i]   <= ram_q[idx_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (host_rd) data_o <= ram_q[addr_i];
  end
endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 4,
  parameter int unsigned STORE_CYC  = 2000,
  parameter int unsigned RECALL_CYC = 300,
  parameter int unsigned CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              store_ni,
  input  logic              recall_ni,
  input  logic              vlow_i,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  store_cnt_o
);
  op_e               op, start_op;
  logic              start, copy_st, copy_rc;
  logic [ADDR_W-1:0] idx;

  nvsram_req u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .store_ni   (store_ni),
    .recall_ni  (recall_ni),
    .vlow_i     (vlow_i),
    .idle_i     (!busy_o),
    .start_o    (start),
    .start_op_o (start_op)
  );

  nvsram_seq #(
    .ADDR_W     (ADDR_W),
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .start_op_i  (start_op),
    .op_o        (op),
    .busy_o      (busy_o),
    .idx_o       (idx),
    .copy_st_o   (copy_st),
    .copy_rc_o   (copy_rc),
    .store_cnt_o (store_cnt_o)
  );

  nvsram_arrays #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .cs_ni     (cs_ni),
    .we_ni     (we_ni),
    .busy_i    (busy_o),
    .idx_i     (idx),
    .copy_st_i (copy_st),
    .copy_rc_i (copy_rc),
    .data_o    (data_o)
  );
endmodule

// File: rtl/nvsram_chk.sv
module nvsram_chk
  import nvsram_pkg::*;
#(
  parameter int unsigned DATA_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              store_ni,
  input logic              recall_ni,
  input logic              vlow_i,
  input logic [DATA_W-1:0] data_o,
  input logic              busy_o,
  input logic [CNT_W-1:0]  store_cnt_o,
  input op_e               op_i
);
  AST_BUSY_HOLDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(data_o)); // R6

  AST_CNT_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(store_cnt_o) |-> store_cnt_o == $past(store_cnt_o) + CNT_W'(1)); // R8

  AST_CNT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(store_cnt_o) |-> $fell(busy_o)); // R8

  AST_NO_STORE_LOW_SUPPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && op_i == OP_STORE) |-> $past(!vlow_i)); // R7

  AST_START_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!store_ni || !recall_ni)); // R11

  AST_RECALL_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && $past(!recall_ni) && $past(recall_ni, 2)) |-> op_i == OP_RECALL); // R9
endmodule

bind nvsram_ctrl nvsram_chk #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .store_ni    (store_ni),
  .recall_ni   (recall_ni),
  .vlow_i      (vlow_i),
  .data_o      (data_o),
  .busy_o      (busy_o),
  .store_cnt_o (store_cnt_o),
  .op_i        (op)
);

// File: tb/nvsram_ctrl_tb.sv
module nvsram_ctrl_tb;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 4;
  localparam int unsigned ST_CYC = 1000;
  localparam int unsigned RC_CYC = 300;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [DATA_W-1:0] data_i = '0;
  logic              cs_ni = 1'b1, we_ni = 1'b1;
  logic              store_ni = 1'b1, recall_ni = 1'b1, vlow_i = 1'b0;
  logic [DATA_W-1:0] data_o;
  logic              busy_o;
  logic [CNT_W-1:0]  store_cnt_o;

  always #10 clk = ~clk;

  nvsram_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_CYC(ST_CYC),
    .RECALL_CYC(RC_CYC), .CNT_W(CNT_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
    .cs_ni(cs_ni), .we_ni(we_ni), .store_ni(store_ni), .recall_ni(recall_ni),
    .vlow_i(vlow_i), .data_o(data_o), .busy_o(busy_o), .store_cnt_o(store_cnt_o)
  );

  typedef struct {
    logic [DATA_W-1:0] exp;
    int                due;
    string             req;
  } item_t;

  item_t sb_q[$];
  int    cyc = 0, total = 0, bad = 0;
  bit    done = 1'b0;
  logic [DATA_W-1:0] last_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DATA_W-1:0] p1(int a);
    return DATA_W'((a * 7 + 3) & 15);
  endfunction
  function automatic logic [DATA_W-1:0] p2(int a);
    return ~p1(a);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // monitor: compare registered read data one edge after the request
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      it = sb_q.pop_front();
      chk(data_o == it.exp, it.req, int'(data_o), int'(it.exp));
    end
  end

  task automatic wr(int a, logic [DATA_W-1:0] d);
    @(negedge clk);
    cs_ni = 1'b0; we_ni = 1'b0; addr_i = ADDR_W'(a); data_i = d;
    @(negedge clk);
    cs_ni = 1'b1; we_ni = 1'b1;
  endtask

  task automatic rd_exp(int a, logic [DATA_W-1:0] exp, string req);
    item_t it;
    @(negedge clk);
    cs_ni = 1'b0; we_ni = 1'b1; addr_i = ADDR_W'(a);
    it.exp = exp; it.due = cyc + 1; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    cs_ni = 1'b1;
  endtask

  task automatic rd(int a, logic [DATA_W-1:0] exp, string req);
    rd_exp(a, exp, req);
    last_rd = exp;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(bit st, bit rc, output int n);
    @(negedge clk);
    store_ni = !st; recall_ni = !rc;
    @(negedge clk);
    store_ni = 1'b1; recall_ni = 1'b1;
    wait_idle(n);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b1, "R10 busy in reset", int'(busy_o), 1);
    chk(store_cnt_o == 0, "R8 cnt reset", int'(store_cnt_o), 0);
    chk(data_o == 0, "R1 data reset", int'(data_o), 0);
    rst_ni = 1'b1;
    wait_idle(n);
    chk(n == RC_CYC, "R10 power-up recall length", n, RC_CYC);

    for (int a = 0; a < DEPTH; a++) wr(a, p1(a));
    rd(0, p1(0), "R1 read 0");
    rd(1, p1(1), "R1 read 1");
    rd(128, p1(128), "R1 read 128");
    rd(255, p1(255), "R1 read 255");

    pulse(1'b1, 1'b0, n);
    chk(n == ST_CYC, "R4 store length", n, ST_CYC);
    chk(store_cnt_o == 1, "R8 cnt after store", int'(store_cnt_o), 1);

    for (int a = 0; a < DEPTH; a++) wr(a, p2(a));
    rd(3, p2(3), "R1 overwrite");
    pulse(1'b0, 1'b1, n);
    chk(n == RC_CYC, "R5 recall length", n, RC_CYC);
    for (int a = 0; a < DEPTH; a++) rd(a, p1(a), "R2 R3 bulk copy");

    // R6: host access during a store is refused
    @(negedge clk); store_ni = 1'b0;
    @(negedge clk); store_ni = 1'b1;
    wr(10, p2(10));
    rd_exp(10, last_rd, "R6 read held while busy");
    wait_idle(n);
    rd(10, p1(10), "R6 write refused");
    chk(store_cnt_o == 2, "R8 cnt second store", int'(store_cnt_o), 2);

    // R7: low supply
    vlow_i = 1'b1;
    wr(0, p2(0));
    pulse(1'b1, 1'b0, n);
    chk(n == 0, "R7 store inhibited busy", n, 0);
    chk(store_cnt_o == 2, "R7 cnt unchanged", int'(store_cnt_o), 2);
    vlow_i = 1'b0;
    pulse(1'b0, 1'b1, n);
    rd(0, p1(0), "R7 shadow unchanged");

    // R9: simultaneous strobes
    wr(5, p2(5));
    pulse(1'b1, 1'b1, n);
    chk(n == RC_CYC, "R9 recall wins length", n, RC_CYC);
    chk(store_cnt_o == 2, "R9 no store counted", int'(store_cnt_o), 2);
    rd(5, p1(5), "R9 recall ran");

    // R9: request while busy dropped
    @(negedge clk); recall_ni = 1'b0;
    @(negedge clk); recall_ni = 1'b1;
    repeat (5) @(negedge clk);
    store_ni = 1'b0;
    @(negedge clk); store_ni = 1'b1;
    wait_idle(n);
    repeat (5) @(negedge clk);
    chk(busy_o == 1'b0, "R9 busy request dropped", int'(busy_o), 0);
    chk(store_cnt_o == 2, "R9 cnt after dropped", int'(store_cnt_o), 2);

    // R11: held strobe runs once
    @(negedge clk); recall_ni = 1'b0;
    @(negedge clk);
    wait_idle(n);
    chk(n == RC_CYC, "R11 held recall length", n, RC_CYC);
    repeat (20) @(negedge clk);
    chk(busy_o == 1'b0, "R11 no retrigger", int'(busy_o), 0);
    recall_ni = 1'b1;

    // R10: reset reloads the shadow
    wr(20, p2(20));
    rd(20, p2(20), "R1 pre-reset write");
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(store_cnt_o == 0, "R8 cnt cleared", int'(store_cnt_o), 0);
    chk(busy_o == 1'b1, "R10 busy in reset", int'(busy_o), 1);
    rst_ni = 1'b1;
    wait_idle(n);
    chk(n == RC_CYC, "R10 reset recall length", n, RC_CYC);
    rd(20, p1(20), "R10 auto recall data");
    repeat (3) @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule